// File: doc/BRIEF.md
# Interrupt Status and Mask Register Block

This block is the interrupt portion of a peripheral's register space. It holds seven interrupt status bits and a seven-bit mask, and it drives one interrupt line. Some status bits are sticky: a one-cycle pulse from the peripheral sets the bit, and it stays set until software writes a one to that bit. Two bits, TX full and RX not-empty, are level sources. They always show the live condition, and software writes do not affect them.

Software cannot write the mask as a whole. A write to the enable offset sets every mask bit that is written as one. A write to the disable offset clears every mask bit that is written as one. A separate read-only offset returns the current mask. The interrupt line is registered. It is high when any status bit that is enabled in the mask is set.

Top module: `irq_regs`

## Requirements
- R1: After reset, the sticky status bits read 0, the mask reads 0 and `irq_o` is low.
- R2: A one-cycle pulse on a sticky source bit (bits 0, 1, 2, 5, 6; bit 1 = mode fault, bit 2 = TX below watermark) sets that bit. The status register at offset 0x04 then reads it as 1 until it is cleared.
- R3: A write to offset 0x04 clears each sticky status bit that is written as one. Bits written as zero keep their value.
- R4: If a source pulse arrives in the same cycle as a write-one-to-clear of the same bit, the bit stays set.
- R5: Level bits (bit 3 = TX full, bit 4 = RX not-empty) read at 0x04 as the live input value. A write to 0x04 does not change them.
- R6: A write to offset 0x08 sets each mask bit that is written as one. Mask bits written as zero keep their value.
- R7: A write to offset 0x0C clears each mask bit that is written as one. Mask bits written as zero keep their value.
- R8: Offset 0x10 reads the mask. Writes to 0x10 are ignored. Offsets 0x08 and 0x0C read as zero.
- R9: `irq_o` is registered. It goes high one clock after some bit is set in both the status and the mask, and low one clock after no such bit remains. All seven defined bits give the all-interrupts value 0x7F.
- R10: Unmapped offsets read as zero, and writes to them change no state. Read data above bit 6 is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte offset, used for both reads and writes |
| wdata | input | 32 | Write data; only bits 6:0 are used |
| evt_in | input | 7 | Event inputs: pulses on sticky bits, levels on bits 3 and 4 |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that:
- a source pulse leaves its sticky bit set, even against a same-cycle clear;
- the enable and disable writes move the mask in the expected direction;
- the mask holds still when no enable or disable write occurs;
- the level bits read live at the status offset;
- `irq_o` follows the masked status with one cycle of delay.

Only the bench scenarios can show the rest:
- that every possible enable and disable pattern leaves the other mask bits alone;
- that every clear pattern removes exactly the bits written as one;
- that the mask readback offset and unmapped offsets ignore writes;
- that `irq_o` settles to the right level for each bit when it is masked alone and when it is masked out.

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NBITS      = 7,
  parameter logic [NBITS-1:0] LEVEL_BITS = 7'h18,
  parameter int OFF_STAT   = 'h04,
  parameter int OFF_SET    = 'h08,
  parameter int OFF_CLR    = 'h0C,
  parameter int OFF_MASK   = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NBITS-1:0]  evt_in,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);

  logic [NBITS-1:0] lat_q, mask_q, stat_view, wbits, clr_bits;
  logic             wr_stat, wr_set, wr_clr, irq_q;

  assign wbits     = wdata[NBITS-1:0];
  assign wr_stat   = wr_en && (addr == A_STAT);
  assign wr_set    = wr_en && (addr == A_SET);
  assign wr_clr    = wr_en && (addr == A_CLR);
  assign clr_bits  = wr_stat ? wbits : '0;
  assign stat_view = (lat_q & ~LEVEL_BITS) | (evt_in & LEVEL_BITS);
  assign irq_o     = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      lat_q <= ((lat_q & ~clr_bits) | evt_in) & ~LEVEL_BITS;
      if (wr_set)
        mask_q <= mask_q | wbits;
      else if (wr_clr)
        mask_q <= mask_q & ~wbits;
      irq_q <= |(stat_view & mask_q);
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_STAT)
      rdata[NBITS-1:0] = stat_view;
    else if (addr == A_MASK)
      rdata[NBITS-1:0] = mask_q;
  end
endmodule

module irq_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NBITS  = 7,
  parameter logic [NBITS-1:0] LEVEL_BITS = 7'h18,
  parameter int OFF_STAT = 'h04
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_set,
  input logic              wr_clr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [NBITS-1:0]  evt_in,
  input logic [DATA_W-1:0] rdata,
  input logic [NBITS-1:0]  lat_q,
  input logic [NBITS-1:0]  mask_q,
  input logic [NBITS-1:0]  stat_view,
  input logic              irq_o
);
  localparam logic [NBITS-1:0] EDGE_BITS = ~LEVEL_BITS;

  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_in & EDGE_BITS) != '0) |=>
      ((lat_q & $past(evt_in & EDGE_BITS)) == $past(evt_in & EDGE_BITS)));

  a_r6_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask_q & $past(wdata[NBITS-1:0])) == $past(wdata[NBITS-1:0])));

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask_q & $past(wdata[NBITS-1:0])) == '0));

  a_r8_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(mask_q));

  a_r5_level_live: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(OFF_STAT)) |->
      ((rdata[NBITS-1:0] & LEVEL_BITS) == (evt_in & LEVEL_BITS)));

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(stat_view & mask_q))));
endmodule

bind irq_regs irq_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBITS(NBITS),
  .LEVEL_BITS(LEVEL_BITS), .OFF_STAT(OFF_STAT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_set(wr_set), .wr_clr(wr_clr),
  .addr(addr), .wdata(wdata), .evt_in(evt_in), .rdata(rdata),
  .lat_q(lat_q), .mask_q(mask_q), .stat_view(stat_view), .irq_o(irq_o)
);

// File: tb/irq_regs_tb.sv
module irq_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [6:0]  evt_in = '0;
  logic [31:0] rdata;
  logic        irq_o;

  localparam logic [6:0] LVL = 7'h18;
  localparam logic [6:0] EDG = 7'h67;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [6:0] lvl = '0;
  logic [31:0] v;

  always #2 clk = ~clk;

  irq_regs dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                  .wdata(wdata), .evt_in(evt_in), .rdata(rdata), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [6:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = {25'd0, d};
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    @(negedge clk); addr = a; #1 r = rdata;
  endtask

  task automatic pulse(input logic [6:0] b);
    @(negedge clk); evt_in = lvl | b;
    @(negedge clk); evt_in = lvl;
  endtask

  task automatic set_lvl(input logic [6:0] l);
    @(negedge clk); lvl = l & LVL; evt_in = lvl;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    rd(8'h04, v); chk("R1 status after reset", v, 32'd0);
    rd(8'h10, v); chk("R1 mask after reset", v, 32'd0);

    for (int m = 0; m < 128; m++) begin
      wr(8'h0C, 7'h7F);
      wr(8'h08, 7'(m));
      rd(8'h10, v); chk("R6 enable pattern", v, 32'(m));
      wr(8'h08, 7'h00);
      rd(8'h10, v); chk("R6 zero enable keeps mask", v, 32'(m));
      wr(8'h0C, ~7'(m));
      rd(8'h10, v); chk("R7 disable other bits keeps mask", v, 32'(m));
      wr(8'h10, 7'h7F);
      rd(8'h10, v); chk("R8 mask readback ignores write", v, 32'(m));
      rd(8'h08, v); chk("R8 enable reads zero", v, 32'd0);
      rd(8'h0C, v); chk("R8 disable reads zero", v, 32'd0);
      wr(8'h0C, 7'(m));
      rd(8'h10, v); chk("R7 disable clears", v, 32'd0);
    end

    for (int c = 0; c < 128; c++) begin
      pulse(EDG);
      rd(8'h04, v); chk("R2 all sticky bits latched", v, 32'(EDG));
      wr(8'h04, 7'(c));
      rd(8'h04, v); chk("R3 w1c pattern", v, 32'(EDG & ~7'(c)));
      wr(8'h04, 7'h7F);
      rd(8'h04, v); chk("R3 clear all", v, 32'd0);
    end

    for (int b = 0; b < 7; b++) begin
      if (EDG[b]) begin
        pulse(7'(1 << b));
        rd(8'h04, v); chk("R2 single pulse", v, 32'(1 << b));
        wr(8'h04, 7'h7F & ~7'(1 << b));
        rd(8'h04, v); chk("R3 zero bit keeps", v, 32'(1 << b));
        @(negedge clk); wr_en = 1'b1; addr = 8'h04; wdata = 32'(1 << b);
        evt_in = 7'(1 << b);
        @(negedge clk); wr_en = 1'b0; evt_in = lvl;
        rd(8'h04, v); chk("R4 event beats clear", v, 32'(1 << b));
        wr(8'h04, 7'h7F);
      end
    end

    set_lvl(7'h08);
    rd(8'h04, v); chk("R5 tx full live", v, 32'h08);
    wr(8'h04, 7'h7F);
    rd(8'h04, v); chk("R5 level not cleared", v, 32'h08);
    set_lvl(7'h10);
    rd(8'h04, v); chk("R5 rx not-empty live", v, 32'h10);
    set_lvl(7'h00);
    rd(8'h04, v); chk("R5 level dropped", v, 32'd0);

    for (int b = 0; b < 7; b++) begin
      wr(8'h0C, 7'h7F);
      wr(8'h08, 7'(1 << b));
      if (EDG[b]) pulse(7'(1 << b));
      else set_lvl(7'(1 << b));
      #1 chk("R9 irq not yet", {31'd0, irq_o}, 32'd0);
      @(negedge clk); #1 chk("R9 irq raised", {31'd0, irq_o}, 32'd1);
      wr(8'h0C, 7'h7F);
      wr(8'h08, 7'h7F & ~7'(1 << b));
      @(negedge clk); #1 chk("R9 irq masked out", {31'd0, irq_o}, 32'd0);
      set_lvl(7'h00);
      wr(8'h04, 7'h7F);
    end
    wr(8'h08, 7'h7F);
    pulse(7'h01);
    @(negedge clk); #1 chk("R9 all-mask irq", {31'd0, irq_o}, 32'd1);
    wr(8'h04, 7'h7F);
    @(negedge clk); #1 chk("R9 irq falls", {31'd0, irq_o}, 32'd0);

    pulse(7'h01);
    wr(8'h14, 7'h7F);
    rd(8'h14, v); chk("R10 unmapped reads zero", v, 32'd0);
    rd(8'h00, v); chk("R10 offset zero reads zero", v, 32'd0);
    rd(8'h10, v); chk("R10 unmapped write keeps mask", v, 32'h7F);
    rd(8'h04, v); chk("R10 unmapped write keeps status", v, 32'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule